// File: doc/BRIEF.md
# CAN Controller Mode and Protection Wrapper

This block sits between a host register bus and a CAN protocol engine. It holds the engine's configuration bytes and ignores host writes to them unless a soft-reset lock bit is set. It shows the engine's transmit and receive error counts to the host as read-only values. It also runs the operating-mode state machine (normal, sleep, soft reset, power down) and derives clock enables for the engine core and the register interface from that mode. In every mode other than normal it holds the transmit pin recessive.

Status events from the engine are latched into flags that the host clears by writing 1. Each flag is masked by its own enable. The masked flags are merged into four interrupt lines: wake-up, error, receive and transmit. Power down is entered from sleep when the system raises a halt request, and it is left when that request drops. The host reads and writes through a flat byte-wide bus with a combinational read path.

Top module: `can_mode_guard`

## Requirements
- R1: After reset the mode is soft reset. Control byte 0x00 reads 0x11: bit0 is the lock bit, bit1 the sleep request, bit2 the sleep acknowledge, and bits 4:3 the mode code (normal 0, sleep 1, soft reset 2, power down 3). All interrupt lines are low, the core clock enable is low and the register clock enable is high.
- R2: A write to a protected configuration byte (0x01 to 0x04 and 0x08 to 0x0F) takes effect only while the lock bit is 1. While the lock bit is 0 the write is ignored.
- R3: A read of a protected byte always returns its stored value, whether or not the lock bit is set. All protected bytes reset to 0.
- R4: The receive error count reads at 0x10 and the transmit error count at 0x11. Both follow the engine's inputs, and host writes to these addresses change nothing.
- R5: The transmit pin is 1 (recessive) in every mode except normal. In normal mode it follows the engine's transmit output.
- R6: The core clock enable is high only in normal mode. The register clock enable is low only in power down.
- R7: Sleep is entered from normal mode one clock after the sleep request is 1 and the bus is idle. While the bus is busy the block stays in normal mode. The acknowledge bit reads 1 in sleep and in power down.
- R8: A wake-up detected in sleep returns the block to normal mode on the next clock, sets the wake flag (bit1 of 0x14) and clears the sleep request. A wake-up detected outside sleep sets nothing.
- R9: Setting the lock bit moves the block to soft reset from normal or sleep mode. In power down the lock bit has no effect until the halt request drops, which returns the block to sleep. Clearing the lock bit in soft reset returns the block to normal mode.
- R10: An event latches its flag. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. The error flags sit at 0x12 (bits 0 to 5) and the receive-full flag at bit0 of 0x14.
- R11: The error line is the OR of the six error flags, each ANDed with its enable bit at 0x13.
- R12: The receive line is the receive-full flag ANDed with bit0 of 0x15. The transmit line is the OR of the three buffer-empty inputs (readable at 0x16), each ANDed with its enable bit at 0x17.
- R13: The wake line is the wake flag ANDed with the wake enable (bit1 of 0x15). The wake flag can only be set while sleep is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write strobe |
| addr | input | AW | Host byte address |
| wrData | input | DW | Host write data |
| rdData | output | DW | Read data for `addr` (combinational) |
| busIdle | input | 1 | Engine reports the CAN bus idle |
| wakeDetect | input | 1 | Engine reports bus activity while asleep |
| haltReq | input | 1 | System request to enter power down |
| txEngine | input | 1 | Transmit bit from the engine |
| txPin | output | 1 | Transmit pin, recessive is 1 |
| rxErrCnt | input | DW | Receive error count from the engine |
| txErrCnt | input | DW | Transmit error count from the engine |
| errEvt | input | 6 | Error event pulses (rx warn, tx warn, rx passive, tx passive, bus-off, overrun) |
| rxFullEvt | input | 1 | Receive-buffer-full event pulse |
| txEmpty | input | 3 | Transmit buffer empty levels |
| coreClkEn | output | 1 | Clock enable for the protocol core |
| regClkEn | output | 1 | Clock enable for register access |
| cfgBits | output | 12*DW | Protected configuration bytes, in index order |
| wakeIrq | output | 1 | Wake-up interrupt |
| errIrq | output | 1 | Error interrupt |
| rxIrq | output | 1 | Receive interrupt |
| txIrq | output | 1 | Transmit interrupt |

## Verification
The bench writes protected bytes on both sides of the lock, including the last mask byte and a byte that has never been written. A design that decoded the lock wrongly would read back the rejected value, or zero in place of an accepted one. It tries writing 0 to a flag and then 1. A design that cleared flags on any write, or that lost a flag to a masked enable, would show it in the readback and on the interrupt lines. It walks the mode machine through a stalled sleep request on a busy bus, a wake-up from sleep and a stray wake-up in normal mode, then power down with a lock write that must wait until the halt request is released. A wrong priority or a missed transition shows up as a wrong mode code, a transmit pin left dominant, or clock enables that do not match the mode.

// File: rtl/cmg_pkg.sv
package cmg_pkg;

  localparam int CFG_N    = 12;
  localparam int CFG_IW   = $clog2(CFG_N);
  localparam int ERR_N    = 6;
  localparam int TXB_N    = 3;

  // protected window bounds: low group then high group
  localparam int CFG_LO_FIRST = 1;
  localparam int CFG_LO_LAST  = 4;
  localparam int CFG_HI_FIRST = 8;
  localparam int CFG_HI_LAST  = 15;

  localparam int ADDR_CTL0   = 0;
  localparam int ADDR_RXCNT  = 16;
  localparam int ADDR_TXCNT  = 17;
  localparam int ADDR_ERRFLG = 18;
  localparam int ADDR_ERREN  = 19;
  localparam int ADDR_RXFLG  = 20;
  localparam int ADDR_RXEN   = 21;
  localparam int ADDR_TXFLG  = 22;
  localparam int ADDR_TXEN   = 23;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_SLEEP   = 2'd1,
    MODE_SOFTRST = 2'd2,
    MODE_PWRDN   = 2'd3
  } mode_e;

  typedef struct packed {
    logic              cfgSel;
    logic [CFG_IW-1:0] cfgIdx;
    logic              cfgWr;
    logic              errFlgWr;
    logic              errEnWr;
    logic              rxFlgWr;
    logic              rxEnWr;
    logic              txEnWr;
    logic              wakeSet;
  } strobe_t;

endpackage

// File: rtl/cmg_ctrl.sv
module cmg_ctrl
  import cmg_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    ctlWrBits,
  input  logic          busIdle,
  input  logic          wakeDetect,
  input  logic          haltReq,
  input  logic          txEngine,
  output strobe_t       strb,
  output logic [DW-1:0] ctlByte,
  output logic          lockOpen,
  output logic          asleep,
  output logic          txPin,
  output logic          coreClkEn,
  output logic          regClkEn
);

  logic [31:0] addrI;
  assign addrI = 32'(addr);

  mode_e state, nextState;
  logic  srstBit, sleepReq;
  logic  ctlWr, wakeExit;

  assign ctlWr = wrEn && (addrI == ADDR_CTL0);

  // Address decode of the protected window
  always_comb begin
    strb.cfgSel = 1'b0;
    strb.cfgIdx = '0;
    if (addrI >= CFG_LO_FIRST && addrI <= CFG_LO_LAST) begin
      strb.cfgSel = 1'b1;
      strb.cfgIdx = CFG_IW'(addrI - CFG_LO_FIRST);
    end else if (addrI >= CFG_HI_FIRST && addrI <= CFG_HI_LAST) begin
      strb.cfgSel = 1'b1;
      strb.cfgIdx = CFG_IW'(addrI - CFG_HI_FIRST + (CFG_LO_LAST - CFG_LO_FIRST + 1));
    end
  end

  assign strb.cfgWr    = wrEn && strb.cfgSel && srstBit;
  assign strb.errFlgWr = wrEn && (addrI == ADDR_ERRFLG);
  assign strb.errEnWr  = wrEn && (addrI == ADDR_ERREN);
  assign strb.rxFlgWr  = wrEn && (addrI == ADDR_RXFLG);
  assign strb.rxEnWr   = wrEn && (addrI == ADDR_RXEN);
  assign strb.txEnWr   = wrEn && (addrI == ADDR_TXEN);
  assign strb.wakeSet  = (state == MODE_SLEEP) && wakeDetect;

  assign wakeExit = (state == MODE_SLEEP) && !srstBit && !haltReq && wakeDetect;

  // Mode sequencing
  always_comb begin
    nextState = state;
    unique case (state)
      MODE_NORMAL: begin
        if (srstBit)                   nextState = MODE_SOFTRST;
        else if (sleepReq && busIdle)  nextState = MODE_SLEEP;
      end
      MODE_SLEEP: begin
        if (srstBit)                   nextState = MODE_SOFTRST;
        else if (haltReq)              nextState = MODE_PWRDN;
        else if (wakeDetect)           nextState = MODE_NORMAL;
        else if (!sleepReq)            nextState = MODE_NORMAL;
      end
      MODE_SOFTRST: begin
        if (!srstBit)                  nextState = MODE_NORMAL;
      end
      MODE_PWRDN: begin
        if (!haltReq)                  nextState = MODE_SLEEP;
      end
      default:                         nextState = MODE_SOFTRST;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= MODE_SOFTRST;
      srstBit  <= 1'b1;
      sleepReq <= 1'b0;
    end else begin
      state <= nextState;
      if (ctlWr) begin
        srstBit  <= ctlWrBits[0];
        sleepReq <= ctlWrBits[1];
      end
      if (wakeExit) sleepReq <= 1'b0;
    end
  end

  assign asleep    = (state == MODE_SLEEP) || (state == MODE_PWRDN);
  assign lockOpen  = srstBit;
  assign coreClkEn = (state == MODE_NORMAL);
  assign regClkEn  = (state != MODE_PWRDN);
  assign txPin     = (state == MODE_NORMAL) ? txEngine : 1'b1;
  assign ctlByte   = DW'({state, asleep, sleepReq, srstBit});

endmodule

// File: rtl/cmg_regs.sv
module cmg_regs
  import cmg_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wrData,
  input  logic [DW-1:0]       ctlByte,
  input  logic [DW-1:0]       rxErrCnt,
  input  logic [DW-1:0]       txErrCnt,
  input  logic [ERR_N-1:0]    errEvt,
  input  logic                rxFullEvt,
  input  logic [TXB_N-1:0]    txEmpty,
  output logic [DW-1:0]       rdData,
  output logic [CFG_N*DW-1:0] cfgBits,
  output logic                wakeIrq,
  output logic                errIrq,
  output logic                rxIrq,
  output logic                txIrq
);

  logic [31:0] addrI;
  assign addrI = 32'(addr);

  logic [DW-1:0]    cfgMem [CFG_N];
  logic [ERR_N-1:0] errFlg, errEn;
  logic             rxFull, wakeFlag;
  logic [1:0]       rxEn;
  logic [TXB_N-1:0] txEn;

  // Protected configuration bytes
  for (genvar gi = 0; gi < CFG_N; gi++) begin : gCfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cfgMem[gi] <= '0;
      else if (strb.cfgWr && (strb.cfgIdx == CFG_IW'(gi)))
        cfgMem[gi] <= wrData;
    end
    assign cfgBits[gi*DW +: DW] = cfgMem[gi];
  end

  // Latched flags (write 1 to clear, event wins) and enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlg   <= '0;
      errEn    <= '0;
      rxFull   <= 1'b0;
      wakeFlag <= 1'b0;
      rxEn     <= '0;
      txEn     <= '0;
    end else begin
      errFlg   <= (errFlg & ~(strb.errFlgWr ? wrData[ERR_N-1:0] : '0)) | errEvt;
      rxFull   <= (rxFull & ~(strb.rxFlgWr && wrData[0])) | rxFullEvt;
      wakeFlag <= (wakeFlag & ~(strb.rxFlgWr && wrData[1])) | strb.wakeSet;
      if (strb.errEnWr) errEn <= wrData[ERR_N-1:0];
      if (strb.rxEnWr)  rxEn  <= wrData[1:0];
      if (strb.txEnWr)  txEn  <= wrData[TXB_N-1:0];
    end
  end

  assign errIrq  = |(errFlg & errEn);
  assign rxIrq   = rxFull & rxEn[0];
  assign txIrq   = |(txEmpty & txEn);
  assign wakeIrq = wakeFlag & rxEn[1];

  always_comb begin
    rdData = '0;
    if (strb.cfgSel) begin
      rdData = cfgMem[strb.cfgIdx];
    end else begin
      case (addrI)
        ADDR_CTL0:   rdData = ctlByte;
        ADDR_RXCNT:  rdData = rxErrCnt;
        ADDR_TXCNT:  rdData = txErrCnt;
        ADDR_ERRFLG: rdData = DW'(errFlg);
        ADDR_ERREN:  rdData = DW'(errEn);
        ADDR_RXFLG:  rdData = DW'({wakeFlag, rxFull});
        ADDR_RXEN:   rdData = DW'(rxEn);
        ADDR_TXFLG:  rdData = DW'(txEmpty);
        ADDR_TXEN:   rdData = DW'(txEn);
        default:     rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/can_mode_guard.sv
module can_mode_guard
  import cmg_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wrData,
  output logic [DW-1:0]       rdData,
  input  logic                busIdle,
  input  logic                wakeDetect,
  input  logic                haltReq,
  input  logic                txEngine,
  output logic                txPin,
  input  logic [DW-1:0]       rxErrCnt,
  input  logic [DW-1:0]       txErrCnt,
  input  logic [ERR_N-1:0]    errEvt,
  input  logic                rxFullEvt,
  input  logic [TXB_N-1:0]    txEmpty,
  output logic                coreClkEn,
  output logic                regClkEn,
  output logic [CFG_N*DW-1:0] cfgBits,
  output logic                wakeIrq,
  output logic                errIrq,
  output logic                rxIrq,
  output logic                txIrq
);

  strobe_t       strb;
  logic [DW-1:0] ctlByte;
  logic          lockOpen;
  logic          asleep;

  cmg_ctrl #(.AW(AW), .DW(DW)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .addr       (addr),
    .ctlWrBits  (wrData[1:0]),
    .busIdle    (busIdle),
    .wakeDetect (wakeDetect),
    .haltReq    (haltReq),
    .txEngine   (txEngine),
    .strb       (strb),
    .ctlByte    (ctlByte),
    .lockOpen   (lockOpen),
    .asleep     (asleep),
    .txPin      (txPin),
    .coreClkEn  (coreClkEn),
    .regClkEn   (regClkEn)
  );

  cmg_regs #(.AW(AW), .DW(DW)) uRegs (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .addr      (addr),
    .wrData    (wrData),
    .ctlByte   (ctlByte),
    .rxErrCnt  (rxErrCnt),
    .txErrCnt  (txErrCnt),
    .errEvt    (errEvt),
    .rxFullEvt (rxFullEvt),
    .txEmpty   (txEmpty),
    .rdData    (rdData),
    .cfgBits   (cfgBits),
    .wakeIrq   (wakeIrq),
    .errIrq    (errIrq),
    .rxIrq     (rxIrq),
    .txIrq     (txIrq)
  );

endmodule

// File: rtl/cmg_checker.sv
module cmg_checker
  import cmg_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [AW-1:0]       addr,
  input logic                wakeDetect,
  input logic                haltReq,
  input logic                busIdle,
  input logic                lockOpen,
  input logic                asleep,
  input logic                txPin,
  input logic                coreClkEn,
  input logic                regClkEn,
  input logic [CFG_N*DW-1:0] cfgBits,
  input logic                wakeIrq
);

  logic cfgAddr;
  assign cfgAddr = ((32'(addr) >= CFG_LO_FIRST) && (32'(addr) <= CFG_LO_LAST)) ||
                   ((32'(addr) >= CFG_HI_FIRST) && (32'(addr) <= CFG_HI_LAST));

  assert_tx_recessive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !coreClkEn |-> txPin);

  assert_pwrdn_gates_core_R6: assert property (@(posedge clk) disable iff (!rstN)
    !regClkEn |-> !coreClkEn);

  assert_locked_cfg_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cfgAddr && !lockOpen) |=> $stable(cfgBits));

  assert_sleep_needs_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asleep) |-> $past(busIdle));

  assert_wake_leaves_sleep_R8: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && regClkEn && wakeDetect && !lockOpen && !haltReq) |=> !asleep);

  assert_wake_irq_origin_R13: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeIrq) |-> ($past(asleep) || $past(wrEn)));

endmodule

bind can_mode_guard cmg_checker #(.AW(AW), .DW(DW)) uChk (.*);

// File: tb/sim_can_mode_guard.sv
`timescale 1ns/1ps
module sim_can_mode_guard;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        busIdle = 1'b1;
  logic        wakeDetect = 1'b0;
  logic        haltReq = 1'b0;
  logic        txEngine = 1'b0;
  logic        txPin;
  logic [7:0]  rxErrCnt = 8'h42;
  logic [7:0]  txErrCnt = 8'h81;
  logic [5:0]  errEvt = '0;
  logic        rxFullEvt = 1'b0;
  logic [2:0]  txEmpty = '0;
  logic        coreClkEn, regClkEn;
  logic [95:0] cfgBits;
  logic        wakeIrq, errIrq, rxIrq, txIrq;

  always #4 clk = ~clk;

  can_mode_guard u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .busIdle(busIdle), .wakeDetect(wakeDetect),
    .haltReq(haltReq), .txEngine(txEngine), .txPin(txPin),
    .rxErrCnt(rxErrCnt), .txErrCnt(txErrCnt), .errEvt(errEvt),
    .rxFullEvt(rxFullEvt), .txEmpty(txEmpty), .coreClkEn(coreClkEn),
    .regClkEn(regClkEn), .cfgBits(cfgBits), .wakeIrq(wakeIrq),
    .errIrq(errIrq), .rxIrq(rxIrq), .txIrq(txIrq)
  );

  // port vector: {0, wake, err, rx, tx, txPin, coreClkEn, regClkEn}
  logic [7:0] portVec;
  assign portVec = {1'b0, wakeIrq, errIrq, rxIrq, txIrq, txPin, coreClkEn, regClkEn};

  typedef struct {
    bit         isPort;
    logic [4:0] a;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sbQ[$];
  int    nChk = 0;
  int    nErr = 0;
  bit    done = 1'b0;

  // monitor: compares queued expectations mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sbQ.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = sbQ.pop_front();
        got = it.isPort ? portVec : rdData;
        nChk++;
        if (got !== it.exp) begin
          nErr++;
          $display("FAIL %s %s@%0h: actual %02h expected %02h", it.tag,
                   it.isPort ? "ports" : "reg", it.a, got, it.exp);
        end
      end
    end
  end

  task automatic chkReg(input logic [4:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addr = a;
    sbQ.push_back('{1'b0, a, e, tag});
    #3;
  endtask

  task automatic chkPort(input logic [7:0] e, input string tag);
    @(negedge clk);
    sbQ.push_back('{1'b1, 5'd0, e, tag});
    #3;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog R1: actual hung run expected completion");
      finishRun();
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;

    // R1 reset state
    chkReg(5'h00, 8'h11, "R1 ctl after reset");
    chkPort(8'h05, "R1 ports after reset");
    chkReg(5'h08, 8'h00, "R3 cfg reset value");

    // R2/R3 writes while lock open
    wr(5'h02, 8'hA5);
    chkReg(5'h02, 8'hA5, "R2 write accepted when locked open");
    wr(5'h0F, 8'h3C);
    chkReg(5'h0F, 8'h3C, "R2 last mask byte accepted");
    wr(5'h01, 8'h77);

    // R9 leave soft reset
    wr(5'h00, 8'h00);
    chkReg(5'h00, 8'h00, "R9 normal after lock cleared");
    chkPort(8'h03, "R6 normal clocks, R5 tx follows engine");
    txEngine = 1'b1;
    chkPort(8'h07, "R5 tx follows engine high");
    txEngine = 1'b0;

    // R2 ignored while locked, R3 readback
    wr(5'h02, 8'h11);
    chkReg(5'h02, 8'hA5, "R2 write ignored when locked");
    wr(5'h08, 8'h99);
    chkReg(5'h08, 8'h00, "R2 acceptance byte unchanged");
    chkReg(5'h01, 8'h77, "R3 readback while locked");

    // R4 counters read only
    wr(5'h10, 8'hFF);
    wr(5'h11, 8'h00);
    chkReg(5'h10, 8'h42, "R4 rx error count");
    chkReg(5'h11, 8'h81, "R4 tx error count");
    rxErrCnt = 8'h07;
    chkReg(5'h10, 8'h07, "R4 count follows engine");

    // R10/R11 error flags
    wr(5'h13, 8'h3F);
    @(negedge clk); errEvt = 6'b000100;
    @(negedge clk); errEvt = '0;
    chkPort(8'h23, "R11 error line raised");
    chkReg(5'h12, 8'h04, "R10 flag latched");
    wr(5'h12, 8'h00);
    chkReg(5'h12, 8'h04, "R10 write 0 keeps flag");
    wr(5'h12, 8'h04);
    chkReg(5'h12, 8'h00, "R10 write 1 clears flag");
    chkPort(8'h03, "R11 error line dropped");
    wr(5'h13, 8'h01);
    @(negedge clk); errEvt = 6'b100000;
    @(negedge clk); errEvt = '0;
    chkPort(8'h03, "R11 masked overrun gives no irq");
    chkReg(5'h12, 8'h20, "R10 overrun flag latched");
    wr(5'h12, 8'h20);

    // R12 receive and transmit lines
    @(negedge clk); rxFullEvt = 1'b1;
    @(negedge clk); rxFullEvt = 1'b0;
    chkPort(8'h03, "R12 rx masked");
    wr(5'h15, 8'h01);
    chkPort(8'h13, "R12 rx line raised");
    wr(5'h14, 8'h01);
    chkPort(8'h03, "R12 rx line cleared");
    txEmpty = 3'b010;
    wr(5'h17, 8'h01);
    chkPort(8'h03, "R12 tx buffer mismatch gives no irq");
    wr(5'h17, 8'h02);
    chkPort(8'h0B, "R12 tx line raised");
    chkReg(5'h16, 8'h02, "R12 tx empty readback");
    txEmpty = 3'b000;
    chkPort(8'h03, "R12 tx line dropped");

    // R7 sleep entry
    busIdle = 1'b0;
    wr(5'h00, 8'h02);
    chkReg(5'h00, 8'h02, "R7 busy bus blocks sleep");
    busIdle = 1'b1;
    idle(1);
    chkReg(5'h00, 8'h0E, "R7 sleep acknowledged");
    chkPort(8'h05, "R5 R6 sleep forces recessive and gates core");

    // R8/R13 wake from sleep
    wr(5'h15, 8'h03);
    @(negedge clk); wakeDetect = 1'b1;
    @(negedge clk); wakeDetect = 1'b0;
    chkReg(5'h00, 8'h00, "R8 wake returns to normal");
    chkPort(8'h43, "R13 wake line raised");
    chkReg(5'h14, 8'h02, "R8 wake flag set");
    wr(5'h14, 8'h02);
    @(negedge clk); wakeDetect = 1'b1;
    @(negedge clk); wakeDetect = 1'b0;
    chkReg(5'h14, 8'h00, "R8 wake outside sleep ignored");
    chkPort(8'h03, "R13 no wake line outside sleep");

    // R9 power down and lock priority
    wr(5'h00, 8'h02);
    idle(1);
    @(negedge clk); haltReq = 1'b1;
    chkReg(5'h00, 8'h1E, "R9 power down entered");
    chkPort(8'h04, "R6 power down gates all");
    wr(5'h00, 8'h03);
    chkReg(5'h00, 8'h1F, "R9 lock held off in power down");
    @(negedge clk); haltReq = 1'b0;
    idle(2);
    chkReg(5'h00, 8'h13, "R9 soft reset after power down released");
    wr(5'h08, 8'h5A);
    chkReg(5'h08, 8'h5A, "R2 write accepted after relock");

    idle(2);
    done = 1'b1;
    finishRun();
  end

endmodule